// File: doc/BRIEF.md
# Byte-Steering ROM Card Read Port

This block is the card side of a read-only memory card with a 16-bit data path split into a low byte lane and a high byte lane. A host presents a byte address, two active-low lane enables and an active-low output enable. The block decodes the upper address bits to choose a ROM bank and reads the addressed 16-bit word. It then steers the even or odd byte of that word onto whichever lane the enables call for. Because the two lane enables are independent, an odd byte can come out on the low lane (8-bit access with A0 high) or on the high lane (high-lane-only access).

Access and release timing are counted in clock cycles. After an address change, or after a lane request appears, a driven lane carries a filler byte until the access count has elapsed. After a lane request is withdrawn, that lane keeps driving its last byte for a separate release count and then stops. The data lanes are modelled as a value plus a per-lane drive enable, which the pad ring turns into a three-state pin. The block also drives the fixed status outputs: write protect high and both card-detect lines low.

Top module: `rom_card_read_port`

## Requirements
- R1: With both lane enables high (standby), neither lane is driven once any release window has run out, whatever the address and output enable do. A drive output of 1 means the lane is driven; 0 means high impedance.
- R2: With the output enable high, neither lane is driven once any release window has run out, even with one or both lane enables low.
- R3: With only the low-lane enable low and the output enable low, the low lane is driven with the even byte (bits 7..0 of the word) when A0 = 0 and the odd byte (bits 15..8) when A0 = 1. The high lane is not driven.
- R4: With only the high-lane enable low and the output enable low, the high lane carries the odd byte (bits 15..8) of the addressed word for either value of A0. The low lane is not driven.
- R5: With both lane enables low and the output enable low, the low lane carries the even byte and the high lane carries the odd byte for either value of A0.
- R6: Address bit 0 is A0. Bits WORD_AW..1 index a word inside a bank, and the BANK_BITS bits above them pick one of 2^BANK_BITS banks. The full byte range is 0 to 2^(WORD_AW+1+BANK_BITS)-1. The word at global word index w = address >> 1 holds (w*40503 + 4660) mod 65536.
- R7: An input change sampled at clock edge t restarts the access count when the address (A0 included) differs from the one sampled at edge t-1, or when a lane request is present at t that was absent at t-1. A lane request is its lane enable low with the output enable low. From the edge of a restart, a requested lane shows FILL (default 0xA5) after edges t through t+ACC_CYC-1, and the addressed byte from edge t+ACC_CYC on.
- R8: When a lane request is absent at edge t, the lane stays driven with its last value after edges t through t+REL_CYC-1. It becomes undriven after edge t+REL_CYC.
- R9: The write-protect output is always 1 and both card-detect outputs are always 0.
- R10: After synchronous reset, both drive outputs are 0 and both lane values are 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_lo_n | input | 1 | Low-lane enable, active low |
| ce_hi_n | input | 1 | High-lane enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address, bit 0 is A0 |
| lo_data_o | output | 8 | Low lane value (bits 7..0 of the card bus) |
| lo_drive_o | output | 1 | Low lane drive enable |
| hi_data_o | output | 8 | High lane value (bits 15..8 of the card bus) |
| hi_drive_o | output | 1 | High lane drive enable |
| wp_o | output | 1 | Write protect, fixed high |
| cd_n_o | output | 2 | Card detect pair, fixed low |

## Verification
The bench goes after lane steering in its three modes. A design that confused them would put the even byte on the low lane in an 8-bit odd access, or let A0 change the byte in word or high-only reads. It also hits bank boundaries and the top of the address range, where a faulty decode returns another bank's word. It probes the timing edges: addresses that change every cycle must never leave filler, an enable asserted on a steady address must still restart the count, and a withdrawn request must keep driving for exactly the release count. An off-by-one counter shows up there as a lane that releases one cycle early or late, or as data that appears a cycle before it is allowed.

// File: rtl/rcp_pkg.sv
package rcp_pkg;

  typedef struct packed {
    logic lo;
    logic hi;
  } lane_req_t;

  // Fixed card contents as a function of the global word index.
  function automatic logic [15:0] rom_word(input int unsigned w);
    logic [31:0] p;
    p = w * 32'd40503 + 32'd4660;
    return p[15:0];
  endfunction

endpackage

// File: rtl/rcp_rom_bank.sv
module rcp_rom_bank #(
  parameter int WORD_AW = 8,
  parameter int BANK_ID = 0
) (
  input  logic               clk,
  input  logic [WORD_AW-1:0] idx_i,
  output logic [15:0]        rd_o
);
  import rcp_pkg::*;

  localparam int DEPTH = 1 << WORD_AW;

  logic [15:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = rom_word(BANK_ID * DEPTH + i);
  end

  always_ff @(posedge clk) rd_o <= mem[idx_i];

endmodule

// File: rtl/rcp_access_timer.sv
module rcp_access_timer #(
  parameter int ADDR_W  = 11,
  parameter int ACC_CYC = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr_i,
  input  rcp_pkg::lane_req_t   req_i,
  output logic                 valid_o
);
  import rcp_pkg::*;

  localparam int AGE_W = $clog2(ACC_CYC + 1);

  logic [AGE_W-1:0]  age_q, age_nxt;
  logic [ADDR_W-1:0] addr_q;
  lane_req_t         req_q;
  logic              restart;

  always_comb begin
    restart = (addr_i != addr_q) || (req_i.lo && !req_q.lo) || (req_i.hi && !req_q.hi);
    if (restart)                          age_nxt = '0;
    else if (age_q == AGE_W'(ACC_CYC))    age_nxt = age_q;
    else                                  age_nxt = age_q + 1'b1;
  end

  assign valid_o = (age_nxt == AGE_W'(ACC_CYC));

  always_ff @(posedge clk) begin
    if (rst) begin
      age_q  <= '0;
      addr_q <= '0;
      req_q  <= '0;
    end else begin
      age_q  <= age_nxt;
      addr_q <= addr_i;
      req_q  <= req_i;
    end
  end

  // R7: data can only be released on an address that was already held the cycle before
  assert_valid_needs_stable_addr_R7: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (addr_i == $past(addr_i)))
    else $error("valid on a freshly changed address");

endmodule

// File: rtl/rcp_lane_driver.sv
module rcp_lane_driver #(
  parameter int         REL_CYC = 2,
  parameter logic [7:0] FILL    = 8'hA5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_i,
  input  logic       valid_i,
  input  logic [7:0] byte_i,
  output logic       drv_o,
  output logic [7:0] data_o
);
  localparam int REL_W = $clog2(REL_CYC + 2);

  logic [REL_W-1:0] rel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_o  <= 1'b0;
      data_o <= '0;
      rel_q  <= '0;
    end else if (req_i) begin
      drv_o  <= 1'b1;
      data_o <= valid_i ? byte_i : FILL;
      rel_q  <= REL_W'(REL_CYC);
    end else begin
      drv_o <= (rel_q != '0);
      if (rel_q != '0) rel_q <= rel_q - 1'b1;
    end
  end

  assert_drive_on_request_R3: assert property (@(posedge clk) disable iff (rst)
    req_i |=> drv_o)
    else $error("requested lane not driven");

  assert_release_done_R8: assert property (@(posedge clk) disable iff (rst)
    (!req_i && rel_q == '0) |=> !drv_o)
    else $error("lane still driven after release window");

  assert_hold_value_R8: assert property (@(posedge clk) disable iff (rst)
    !req_i |=> $stable(data_o))
    else $error("lane value moved without a request");

  assert_fill_before_ready_R7: assert property (@(posedge clk) disable iff (rst)
    (req_i && !valid_i) |=> (data_o == FILL))
    else $error("lane shows data before the access count elapsed");

endmodule

// File: rtl/rom_card_read_port.sv
module rom_card_read_port #(
  parameter int         WORD_AW   = 8,
  parameter int         BANK_BITS = 2,
  parameter int         ACC_CYC   = 3,
  parameter int         REL_CYC   = 2,
  parameter logic [7:0] FILL      = 8'hA5,
  localparam int        ADDR_W    = WORD_AW + 1 + BANK_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_lo_n,
  input  logic              ce_hi_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        lo_data_o,
  output logic              lo_drive_o,
  output logic [7:0]        hi_data_o,
  output logic              hi_drive_o,
  output logic              wp_o,
  output logic [1:0]        cd_n_o
);
  import rcp_pkg::*;

  localparam int NUM_BANKS = 1 << BANK_BITS;

  lane_req_t          req;
  logic               valid;
  logic [WORD_AW-1:0] word_idx;
  logic [15:0]        bank_rd [NUM_BANKS];
  logic [15:0]        word_q;
  logic [1:0]         lane_req;
  logic [7:0]         lane_byte [2];
  logic [1:0]         lane_drv;
  logic [7:0]         lane_data [2];

  assign req.lo   = !ce_lo_n && !oe_n;
  assign req.hi   = !ce_hi_n && !oe_n;
  assign word_idx = addr[WORD_AW:1];

  // Bank array: one ROM per bank, all read in parallel, result picked by the registered bank field.
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    rcp_rom_bank #(.WORD_AW(WORD_AW), .BANK_ID(b)) u_bank (
      .clk   (clk),
      .idx_i (word_idx),
      .rd_o  (bank_rd[b])
    );
  end

  if (BANK_BITS > 0) begin : g_multi
    logic [BANK_BITS-1:0] bank_q;
    always_ff @(posedge clk) bank_q <= addr[ADDR_W-1:WORD_AW+1];
    assign word_q = bank_rd[bank_q];
  end else begin : g_single
    assign word_q = bank_rd[0];
  end

  rcp_access_timer #(.ADDR_W(ADDR_W), .ACC_CYC(ACC_CYC)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .addr_i  (addr),
    .req_i   (req),
    .valid_o (valid)
  );

  // Steering: the low lane takes the odd byte only in a low-lane-only access with A0 set.
  assign lane_req[0]  = req.lo;
  assign lane_req[1]  = req.hi;
  assign lane_byte[0] = (ce_hi_n && addr[0]) ? word_q[15:8] : word_q[7:0];
  assign lane_byte[1] = word_q[15:8];

  for (genvar l = 0; l < 2; l++) begin : g_lane
    rcp_lane_driver #(.REL_CYC(REL_CYC), .FILL(FILL)) u_lane (
      .clk     (clk),
      .rst     (rst),
      .req_i   (lane_req[l]),
      .valid_i (valid),
      .byte_i  (lane_byte[l]),
      .drv_o   (lane_drv[l]),
      .data_o  (lane_data[l])
    );
  end

  assign lo_drive_o = lane_drv[0];
  assign lo_data_o  = lane_data[0];
  assign hi_drive_o = lane_drv[1];
  assign hi_data_o  = lane_data[1];
  assign wp_o       = 1'b1;
  assign cd_n_o     = 2'b00;

  // R1: in standby an idle lane stays idle
  assert_standby_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (ce_lo_n && ce_hi_n && !lo_drive_o && !hi_drive_o) |=> (!lo_drive_o && !hi_drive_o))
    else $error("lane driven in standby");

  // R2: output enable high keeps an idle lane idle
  assert_oe_gates_R2: assert property (@(posedge clk) disable iff (rst)
    (oe_n && !lo_drive_o && !hi_drive_o) |=> (!lo_drive_o && !hi_drive_o))
    else $error("lane driven with output enable high");

endmodule

// File: tb/sim_rom_card_read_port.sv
module sim_rom_card_read_port;

  localparam int         WORD_AW   = 8;
  localparam int         BANK_BITS = 2;
  localparam int         ACC       = 3;
  localparam int         REL       = 2;
  localparam logic [7:0] FILL      = 8'hA5;
  localparam int         ADDR_W    = WORD_AW + 1 + BANK_BITS;
  localparam int         TOP_ADDR  = (1 << ADDR_W) - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ce_lo_n = 1'b1, ce_hi_n = 1'b1, oe_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        lo_data_o, hi_data_o;
  logic              lo_drive_o, hi_drive_o, wp_o;
  logic [1:0]        cd_n_o;

  always #2 clk = ~clk;

  rom_card_read_port #(
    .WORD_AW(WORD_AW), .BANK_BITS(BANK_BITS), .ACC_CYC(ACC), .REL_CYC(REL), .FILL(FILL)
  ) u0 (
    .clk(clk), .rst(rst), .ce_lo_n(ce_lo_n), .ce_hi_n(ce_hi_n), .oe_n(oe_n), .addr(addr),
    .lo_data_o(lo_data_o), .lo_drive_o(lo_drive_o), .hi_data_o(hi_data_o),
    .hi_drive_o(hi_drive_o), .wp_o(wp_o), .cd_n_o(cd_n_o)
  );

  int    vectors = 0;
  int    errors  = 0;
  bit    done    = 0;
  string tag     = "R10";

  // Reference model state
  int       prev_addr = 0;
  bit       prev_lo = 0, prev_hi = 0;
  int       age = 0;
  int       rel_lo = 0, rel_hi = 0;
  bit       e_lo_drv = 0, e_hi_drv = 0;
  bit [7:0] e_lo = 0, e_hi = 0;

  function automatic bit [15:0] card_word(int w);
    int unsigned p;
    p = w * 40503 + 4660;
    return p[15:0];
  endfunction

  task automatic model_edge();
    bit lo_r, hi_r, restart, ok;
    bit [15:0] w;
    lo_r = !ce_lo_n && !oe_n;
    hi_r = !ce_hi_n && !oe_n;
    restart = (int'(addr) != prev_addr) || (lo_r && !prev_lo) || (hi_r && !prev_hi);
    if (restart) age = 0; else if (age < ACC) age++;
    ok = (age >= ACC);
    w = card_word(int'(addr) >> 1);
    if (lo_r) begin
      e_lo_drv = 1; rel_lo = REL;
      e_lo = !ok ? FILL : ((ce_hi_n && addr[0]) ? w[15:8] : w[7:0]);
    end else begin
      e_lo_drv = (rel_lo > 0);
      if (rel_lo > 0) rel_lo--;
    end
    if (hi_r) begin
      e_hi_drv = 1; rel_hi = REL;
      e_hi = ok ? w[15:8] : FILL;
    end else begin
      e_hi_drv = (rel_hi > 0);
      if (rel_hi > 0) rel_hi--;
    end
    prev_addr = int'(addr); prev_lo = lo_r; prev_hi = hi_r;
  endtask

  task automatic compare();
    vectors++;
    if (lo_drive_o !== e_lo_drv) begin
      errors++; $display("FAIL %s lo_drive got %0b exp %0b", tag, lo_drive_o, e_lo_drv);
    end
    if (hi_drive_o !== e_hi_drv) begin
      errors++; $display("FAIL %s hi_drive got %0b exp %0b", tag, hi_drive_o, e_hi_drv);
    end
    if ((e_lo_drv || tag == "R10") && lo_data_o !== e_lo) begin
      errors++; $display("FAIL %s lo_data got %02h exp %02h", tag, lo_data_o, e_lo);
    end
    if ((e_hi_drv || tag == "R10") && hi_data_o !== e_hi) begin
      errors++; $display("FAIL %s hi_data got %02h exp %02h", tag, hi_data_o, e_hi);
    end
    if (wp_o !== 1'b1 || cd_n_o !== 2'b00) begin
      errors++; $display("FAIL R9 status got wp=%0b cd=%02b exp wp=1 cd=00", wp_o, cd_n_o);
    end
  endtask

  task automatic apply(bit lo_n, bit hi_n, bit o_n, int a, int n);
    ce_lo_n = lo_n; ce_hi_n = hi_n; oe_n = o_n; addr = ADDR_W'(a);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare();
    end
  endtask

  initial begin : watchdog
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    tag = "R10";
    compare();                           // reset state, no edge yet out of reset

    tag = "R1";                          // standby with address and output enable moving
    for (int i = 0; i < 8; i++) apply(1, 1, i % 2, i * 37, 1);

    tag = "R2";                          // enables low, output enable high
    for (int i = 0; i < 8; i++) apply(0, 0, 1, i * 53, 1);
    apply(0, 1, 1, 12, 3);
    apply(1, 0, 1, 13, 3);

    tag = "R3";                          // low lane only: even then odd byte
    apply(0, 1, 0, 10'h2A4, 6);
    apply(0, 1, 0, 10'h2A5, 6);
    apply(0, 1, 0, 11, 6);

    tag = "R4";                          // high lane only: A0 must not change the byte
    apply(1, 0, 0, 200, 6);
    apply(1, 0, 0, 201, 6);

    tag = "R5";                          // word read, both A0 values
    apply(0, 0, 0, 300, 6);
    apply(0, 0, 0, 301, 6);

    tag = "R6";                          // bank boundaries and range ends
    for (int b = 0; b < (1 << BANK_BITS); b++) begin
      apply(0, 0, 0, b << (WORD_AW + 1), 5);
      apply(0, 0, 0, ((b + 1) << (WORD_AW + 1)) - 1, 5);
    end
    apply(0, 1, 0, TOP_ADDR, 5);
    apply(0, 1, 0, 0, 5);

    tag = "R7";                          // address changing every cycle never settles
    for (int i = 0; i < 10; i++) apply(0, 0, 0, 500 + i, 1);
    apply(0, 0, 0, 509, 5);
    apply(1, 1, 0, 509, 2);              // enables dropped on a steady address
    apply(0, 1, 0, 509, 5);              // re-asserted: count restarts
    apply(0, 0, 0, 509, 5);              // second lane added: count restarts

    tag = "R8";                          // release windows
    apply(0, 0, 0, 700, 5);
    apply(0, 0, 1, 700, 5);
    apply(0, 0, 0, 701, 5);
    apply(1, 0, 0, 701, 5);
    apply(1, 1, 0, 1500, 5);

    tag = "R7";                          // mixed pseudo-random traffic
    for (int i = 0; i < 600; i++) begin
      int unsigned r;
      r = $urandom;
      apply(r[0] & r[1], r[2] & r[3], r[4] & r[5] & r[6], int'(r[31:16]) & TOP_ADDR, 1 + int'(r[8:7]) * (r[9] ? 2 : 0));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule